// File: doc/BRIEF.md
# Output Divider with Synchronous Enable

This block takes a high-speed VCO clock and produces a slower output clock. The division ratio is one of 1, 2, 4 or 8, picked by a 2-bit code that comes from the configuration latches. An active-high enable gates the output. The enable and the ratio code are sampled only at the boundary between two output periods. Because of this, every pulse on the output is whole: no pulse is cut short and no extra runt pulse appears.

For ratios 2, 4 and 8 the output is a registered square wave with a 50% duty cycle. For ratio 1 the VCO clock itself is passed through a gate. That gate opens and closes only while the VCO clock is low. While the output is disabled it stays low. When pins are left open, the surrounding logic is expected to tie the code and the enable high, which gives pass-through with the output on.

Top module: `out_div_sync`

## Requirements
- R1: While reset is asserted the output is low. After reset is released, the output stays low during the first VCO cycle and then follows the sampled code and enable.
- R2: Code 2'b00 divides by 2: high for 1 VCO cycle, then low for 1.
- R3: Code 2'b01 divides by 4: high for 2 VCO cycles, then low for 2.
- R4: Code 2'b10 divides by 8: high for 4 VCO cycles, then low for 4.
- R5: Code 2'b11 passes the VCO clock through. While enabled, the output is high during the VCO high phase and low during the VCO low phase.
- R6: While the sampled enable is low, the output is held low through every phase of the VCO clock.
- R7: A change on the enable takes effect only at the start of an output period. A pulse that has begun is always completed at full width.
- R8: A change of the ratio code takes effect only at the start of an output period. The current period always runs to its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | High-speed input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_sel | input | 2 | Ratio code: 00=/2, 01=/4, 10=/8, 11=/1 |
| oe_in | input | 1 | Active-high output enable |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
The bench runs every ratio code long enough to cover several output periods. This separates the four ratios and shows the duty cycle. It also checks both VCO phases, which is what tells the registered divided path apart from the gated pass-through path. The enable and the code are changed at arbitrary cycles in the middle of a period, so a design that acts on them at once, instead of at the wrap, shows a truncated or stretched pulse. One long disabled stretch, and enable toggles while in pass-through, cover the hold-low behaviour and the gating done on the falling edge.

// File: rtl/out_div_sync.sv
module out_div_sync #(
  parameter int MAX_DIV = 8
) (
  input  logic       vco_clk,
  input  logic       rst_n,
  input  logic [1:0] n_sel,
  input  logic       oe_in,
  output logic       clk_out
);
  localparam int CW = $clog2(MAX_DIV);
  localparam int RW = CW + 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic [RW-1:0] ratio_q, ratio_n, code_ratio;
  logic          en_q, en_n, div_q, byp_q, wrap;

  always_comb begin
    case (n_sel)
      2'b00:   code_ratio = RW'(2);
      2'b01:   code_ratio = RW'(4);
      2'b10:   code_ratio = RW'(8);
      default: code_ratio = RW'(1);
    endcase
  end

  assign wrap    = ({1'b0, cnt_q} == ratio_q - RW'(1));
  assign cnt_n   = wrap ? '0 : cnt_q + CW'(1);
  assign ratio_n = wrap ? code_ratio : ratio_q;
  assign en_n    = wrap ? oe_in : en_q;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RW'(1);
      en_q    <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      en_q    <= en_n;
      div_q   <= en_n & ({1'b0, cnt_n} < (ratio_n >> 1));
    end
  end

  // pass-through gate changes only while the VCO clock is low
  always_ff @(negedge vco_clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= en_q & (ratio_q == RW'(1));
  end

  assign clk_out = div_q | (vco_clk & byp_q);
endmodule

module out_div_sync_chk #(
  parameter int CW = 3,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          wrap,
  input logic          div_q,
  input logic [CW-1:0] cnt_q,
  input logic [RW-1:0] ratio_q
);
  a_r7_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(en_q));
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));
  a_r4_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ratio_q) == 1);
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < ratio_q);
  a_r5_no_divided_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RW'(1)) |-> !div_q);
  a_r6_off_means_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> !div_q);
endmodule

bind out_div_sync out_div_sync_chk #(.CW(CW), .RW(RW)) chk_i (
  .clk(vco_clk), .rst_n(rst_n), .en_q(en_q), .wrap(wrap),
  .div_q(div_q), .cnt_q(cnt_q), .ratio_q(ratio_q)
);

// File: tb/out_div_sync_tb.sv
module out_div_sync_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oe = 1'b0;
  logic [1:0] n_sel = 2'b11;
  logic       clk_out;

  always #2 clk = ~clk;

  out_div_sync dut_i (
    .vco_clk(clk), .rst_n(rst_n), .n_sel(n_sel), .oe_in(oe), .clk_out(clk_out)
  );

  int    checks = 0;
  int    fails = 0;
  string tag = "R1";
  bit    done = 1'b0;
  int    m_cnt = 0, m_ratio = 1, m_en = 0, m_g1 = 0, m_div = 0;

  function automatic int dec(logic [1:0] c);
    case (c)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(logic act, logic exp, string ph);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s phase) at %0t: clk_out=%b expected %b", tag, ph, $time, act, exp);
    end
  endtask

  // reference model: period position, ratio and enable taken at each period start
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_ratio = 1; m_en = 0; m_div = 0;
    end else begin
      if (m_cnt == m_ratio - 1) begin
        m_cnt = 0; m_ratio = dec(n_sel); m_en = oe ? 1 : 0;
      end else m_cnt++;
      m_div = (m_en != 0 && m_cnt < m_ratio / 2) ? 1 : 0;
    end
    #1 chk(clk_out, (m_div != 0) || (m_g1 != 0), "high");
    @(negedge clk);
    m_g1 = (rst_n && m_en != 0 && m_ratio == 1) ? 1 : 0;
    #1 chk(clk_out, m_div != 0, "low");
  end

  task automatic drive(logic [1:0] n, logic o, int cyc, string t);
    @(negedge clk); #1;
    n_sel = n; oe = o; tag = t;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1; oe = 1'b1; n_sel = 2'b11;
    repeat (3) @(negedge clk);
    drive(2'b11, 1'b1, 10, "R5");
    drive(2'b00, 1'b1, 12, "R2");
    drive(2'b01, 1'b1, 21, "R3");
    drive(2'b10, 1'b1, 35, "R4");
    drive(2'b10, 1'b0, 3,  "R7");
    drive(2'b10, 1'b0, 20, "R6");
    drive(2'b10, 1'b1, 5,  "R7");
    drive(2'b10, 1'b1, 14, "R4");
    drive(2'b00, 1'b1, 3,  "R8");
    drive(2'b01, 1'b1, 9,  "R8");
    drive(2'b10, 1'b1, 2,  "R8");
    drive(2'b11, 1'b1, 13, "R8");
    drive(2'b11, 1'b0, 6,  "R7");
    drive(2'b11, 1'b1, 6,  "R5");
    drive(2'b01, 1'b0, 10, "R6");
    drive(2'b00, 1'b1, 8,  "R2");
    @(negedge clk); #1 rst_n = 1'b0; tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1; n_sel = 2'b00;
    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule